// File: doc/BRIEF.md
# Status Coprocessor Register Bank

This block is a bank of 32 auxiliary 32-bit registers that sits next to a simple core's main register file. The execute stage reads it combinationally, through a 5-bit index, to serve a move-from instruction. It writes the bank through a valid/ready write port to serve a move-to instruction. The core's decoder sends an access here only when the operand is tagged as a coprocessor register. Normal-tagged operands never reach this bank.

Every accepted write also goes into a small output queue. The queue drains toward the host as a valid/ready stream of (index, value) pairs, so the host sees every result the program reports. One index is reserved for the program's pass/fail outcome. Two read-only indices expose free-running counters: cycles elapsed and instructions retired. The host pulse that launches the core clears both counters. The core raises the retire strobe once for every completed instruction, even when that instruction writes nothing here.

Top module: `cop_bank`

## Requirements
- R1: After reset, host_valid_o is 0, wr_ready_o is 1, and every index reads 0.
- R2: Indices 0 to 7 and index 21 (the pass/fail result register) are storage. An accepted write to one of them is returned by a read of that index from the next cycle on.
- R3: Any index that is neither storage nor a counter always reads 0. A write to such an index changes no register, but it is still forwarded to the host.
- R4: Index 10 reads the cycle counter. It stays 0 until start_i is seen. The cycle in which start_i is sampled sets it to 0. It then increases by exactly 1 on each later clock edge.
- R5: Index 11 reads the retired-instruction counter. It increases by 1 on each edge where retire_i is high and the core is running. Retire pulses before the first start are ignored.
- R6: A write to index 10 or 11 is forwarded to the host but leaves both counters unchanged.
- R7: Each accepted write (wr_valid_i and wr_ready_o both high) adds exactly one entry with its index and data to the host stream. Entries leave in the order they were accepted.
- R8: The queue holds 2 entries. While it is full, wr_ready_o is 0. A write offered while wr_ready_o is 0 is neither stored nor forwarded.
- R9: While host_valid_o is 1 and host_ready_i is 0, host_valid_o, host_idx_o and host_data_o hold their values on the next cycle.
- R10: A start_i pulse while the core is already running clears both counters to 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host launch pulse; clears the counters and marks the core running |
| retire_i | input | 1 | One pulse per completed instruction |
| rd_idx_i | input | 5 | Move-from read index |
| rd_data_o | output | 32 | Combinational read data |
| wr_valid_i | input | 1 | Move-to write request |
| wr_ready_o | output | 1 | Write can be accepted (queue not full) |
| wr_idx_i | input | 5 | Move-to write index |
| wr_data_i | input | 32 | Move-to write data |
| host_valid_o | output | 1 | Host stream entry available |
| host_ready_i | input | 1 | Host takes the entry |
| host_idx_o | output | 5 | Index of the head entry |
| host_data_o | output | 32 | Data of the head entry |

## Verification
The assertions run on every cycle and cover the stream and counter rules that hold at any moment:
- the full queue blocks writes;
- an accepted write makes the stream non-empty;
- a stalled head entry stays stable;
- unimplemented indices read zero;
- the cycle counter steps by one;
- the retire counter stays still without a pulse;
- a start pulse clears the counter.

Other behaviour needs a known history, so only the bench's scenarios can show it:
- the exact counter values;
- the order of entries in the stream;
- that a dropped write reaches neither storage nor the host;
- that counter-index writes are ignored while the core runs.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int unsigned DATA_W_D  = 32;
  localparam int unsigned IDX_W_D   = 5;
  localparam int unsigned CYC_IDX_D = 10;
  localparam int unsigned RET_IDX_D = 11;
  localparam int unsigned RES_IDX_D = 21;
  localparam int unsigned NUM_GP_D  = 8;

  // storage: low general slots plus the result slot, never a counter slot
  function automatic bit is_stored(int unsigned i, int unsigned num_gp,
                                   int unsigned cyc, int unsigned ret,
                                   int unsigned res);
    if (i == cyc || i == ret) return 1'b0;
    return (i < num_gp) || (i == res);
  endfunction
endpackage

// File: rtl/cop_counters.sv
module cop_counters #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              retire_i,
  output logic [DATA_W-1:0] cyc_o,
  output logic [DATA_W-1:0] ret_o
);
  logic running_q;
  logic [DATA_W-1:0] cyc_q, ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cyc_q     <= '0;
      ret_q     <= '0;
    end else if (start_i) begin
      running_q <= 1'b1;
      cyc_q     <= '0;
      ret_q     <= '0;
    end else if (running_q) begin
      cyc_q <= cyc_q + 1'b1;
      if (retire_i) ret_q <= ret_q + 1'b1;
    end
  end

  assign cyc_o = cyc_q;
  assign ret_o = ret_q;
endmodule

// File: rtl/cop_storage.sv
module cop_storage
  import cop_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned NUM_GP  = 8,
  parameter int unsigned CYC_IDX = 10,
  parameter int unsigned RET_IDX = 11,
  parameter int unsigned RES_IDX = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [DATA_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (is_stored(i, NUM_GP, CYC_IDX, RET_IDX, RES_IDX)) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs[i] <= '0;
        else if (we_i && wr_idx_i == IDX_W'(i)) regs[i] <= wr_data_i;
      end
    end else begin : g_zero
      assign regs[i] = '0;
    end
  end

  assign rd_data_o = regs[rd_idx_i];
endmodule

// File: rtl/cop_fifo.sv
module cop_fifo #(
  parameter int unsigned W     = 37,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign data_o  = mem[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp_q] <= data_i;
        wp_q      <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cop_bank.sv
module cop_bank
  import cop_pkg::*;
#(
  parameter int unsigned DATA_W     = DATA_W_D,
  parameter int unsigned IDX_W      = IDX_W_D,
  parameter int unsigned FIFO_DEPTH = 2,
  parameter int unsigned NUM_GP     = NUM_GP_D,
  parameter int unsigned CYC_IDX    = CYC_IDX_D,
  parameter int unsigned RET_IDX    = RET_IDX_D,
  parameter int unsigned RES_IDX    = RES_IDX_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              retire_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              host_valid_o,
  input  logic              host_ready_i,
  output logic [IDX_W-1:0]  host_idx_o,
  output logic [DATA_W-1:0] host_data_o
);
  localparam int unsigned ENT_W = IDX_W + DATA_W;

  logic              wr_fire, q_full;
  logic [DATA_W-1:0] cyc, ret, st_rd;
  logic [ENT_W-1:0]  q_head;

  assign wr_ready_o = !q_full;
  assign wr_fire    = wr_valid_i && wr_ready_o;

  cop_counters #(.DATA_W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .retire_i(retire_i), .cyc_o(cyc), .ret_o(ret)
  );

  cop_storage #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_GP(NUM_GP),
    .CYC_IDX(CYC_IDX), .RET_IDX(RET_IDX), .RES_IDX(RES_IDX)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_fire),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(st_rd)
  );

  cop_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_q (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(wr_fire), .data_i({wr_idx_i, wr_data_i}), .full_o(q_full),
    .pop_i(host_ready_i), .valid_o(host_valid_o), .data_o(q_head)
  );

  assign host_idx_o  = q_head[ENT_W-1:DATA_W];
  assign host_data_o = q_head[DATA_W-1:0];

  always_comb begin
    if (rd_idx_i == IDX_W'(CYC_IDX))      rd_data_o = cyc;
    else if (rd_idx_i == IDX_W'(RET_IDX)) rd_data_o = ret;
    else                                  rd_data_o = st_rd;
  end
endmodule

// File: rtl/cop_bank_chk.sv
module cop_bank_chk
  import cop_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned NUM_GP  = 8,
  parameter int unsigned CYC_IDX = 10,
  parameter int unsigned RET_IDX = 11,
  parameter int unsigned RES_IDX = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              retire_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic              host_valid_o,
  input logic              host_ready_i,
  input logic [IDX_W-1:0]  host_idx_o,
  input logic [DATA_W-1:0] host_data_o
);
  logic rd_unimpl;
  assign rd_unimpl = !is_stored(32'(rd_idx_i), NUM_GP, CYC_IDX, RET_IDX, RES_IDX)
                     && rd_idx_i != IDX_W'(CYC_IDX) && rd_idx_i != IDX_W'(RET_IDX);

  p_full_not_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |-> host_valid_o);

  p_push_visible_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o |=> host_valid_o);

  p_hold_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_o && !host_ready_i |=>
      host_valid_o && $stable(host_idx_o) && $stable(host_data_o));

  p_unimpl_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unimpl |-> rd_data_o == '0);

  p_cyc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == IDX_W'(CYC_IDX) && $past(rd_idx_i == IDX_W'(CYC_IDX)) &&
    !$past(start_i) && $past(rd_data_o) != '0 |-> rd_data_o == $past(rd_data_o) + 1'b1);

  p_start_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) && rd_idx_i == IDX_W'(CYC_IDX) |-> rd_data_o == '0);

  p_ret_still_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == IDX_W'(RET_IDX) && $past(rd_idx_i == IDX_W'(RET_IDX)) &&
    !$past(retire_i) && !$past(start_i) |-> $stable(rd_data_o));
endmodule

bind cop_bank cop_bank_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_GP(NUM_GP),
  .CYC_IDX(CYC_IDX), .RET_IDX(RET_IDX), .RES_IDX(RES_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .retire_i(retire_i),
  .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .wr_valid_i(wr_valid_i),
  .wr_ready_o(wr_ready_o), .host_valid_o(host_valid_o),
  .host_ready_i(host_ready_i), .host_idx_o(host_idx_o), .host_data_o(host_data_o)
);

// File: tb/cop_bank_bench.sv
module cop_bank_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 7;

  // write index, write data, expected read-back
  localparam logic [4:0]  V_IDX [NV] = '{5'd0, 5'd7, 5'd21, 5'd15, 5'd31, 5'd3, 5'd8};
  localparam logic [31:0] V_DAT [NV] = '{32'hA5A5_0001, 32'h0000_7777, 32'h0000_0001,
                                        32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h1234_5678,
                                        32'h0BAD_F00D};
  localparam logic [31:0] V_EXP [NV] = '{32'hA5A5_0001, 32'h0000_7777, 32'h0000_0001,
                                        32'h0, 32'h0, 32'h1234_5678, 32'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, retire = 1'b0, wr_valid = 1'b0, host_ready = 1'b0;
  logic [4:0]  rd_idx = '0, wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, host_data;
  logic [4:0]  host_idx;
  logic        wr_ready, host_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_bank u_cop_bank (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .retire_i(retire),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .host_valid_o(host_valid), .host_ready_i(host_ready),
    .host_idx_o(host_idx), .host_data_o(host_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] i, output logic [31:0] v);
    rd_idx = i;
    #1;
    v = rd_data;
  endtask

  task automatic wr(logic [4:0] i, logic [31:0] d);
    wr_valid = 1'b1; wr_idx = i; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(string req, logic [4:0] ei, logic [31:0] ed);
    check(req, 32'(host_valid), 32'd1);
    check(req, 32'(host_idx), 32'(ei));
    check(req, host_data, ed);
    host_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    host_ready = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 host_valid", 32'(host_valid), 32'd0);
    check("R1 wr_ready", 32'(wr_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'd21, v); check("R1 result reg", v, 32'd0);
    rd(5'd10, v); check("R1 cycle reg", v, 32'd0);

    // R2 R3 R7 table walk
    for (int k = 0; k < NV; k++) begin
      wr(V_IDX[k], V_DAT[k]);
      pop("R7 forward", V_IDX[k], V_DAT[k]);
      rd(V_IDX[k], v);
      check((V_EXP[k] == V_DAT[k]) ? "R2 readback" : "R3 unimpl", v, V_EXP[k]);
    end
    check("R7 drained", 32'(host_valid), 32'd0);

    // R4 R5 before start
    retire = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); retire = 1'b0;
    rd(5'd11, v); check("R5 retire before start", v, 32'd0);
    rd(5'd10, v); check("R4 idle cycle count", v, 32'd0);

    // R4 start and count
    start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    rd(5'd10, v); check("R4 cleared on start", v, 32'd0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(5'd10, v); check("R4 five cycles", v, 32'd5);

    // R5 retire count
    retire = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); retire = 1'b0;
    rd(5'd11, v); check("R5 three retires", v, 32'd3);

    // R6 write to counters ignored
    rd(5'd10, c0);
    wr(5'd10, 32'hFFFF_0000);
    rd(5'd10, v); check("R6 cycle unaffected", v, c0 + 32'd1);
    pop("R6 forward", 5'd10, 32'hFFFF_0000);
    wr(5'd11, 32'h0000_00AA);
    rd(5'd11, v); check("R6 retire unaffected", v, 32'd3);
    pop("R6 forward", 5'd11, 32'h0000_00AA);

    // R8 R9 full queue
    wr(5'd1, 32'h1111_1111);
    wr(5'd2, 32'h2222_2222);
    check("R8 not ready when full", 32'(wr_ready), 32'd0);
    check("R9 head idx", 32'(host_idx), 32'd1);
    wr(5'd2, 32'h9999_9999);
    check("R9 head held", host_data, 32'h1111_1111);
    rd(5'd2, v); check("R8 dropped not stored", v, 32'h2222_2222);
    pop("R8 order first", 5'd1, 32'h1111_1111);
    pop("R8 order second", 5'd2, 32'h2222_2222);
    check("R8 dropped not forwarded", 32'(host_valid), 32'd0);

    // R10 restart
    start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    rd(5'd10, v); check("R10 cycle restart", v, 32'd0);
    rd(5'd11, v); check("R10 retire restart", v, 32'd0);

    summary();
  end
endmodule